// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the program order of in-flight instructions in a speculative out-of-order core. The issue stage claims one slot per instruction and receives that slot's index as the tag under which the instruction's result will later appear. Execution units broadcast finished results, each with its tag, on a shared result bus. The buffer records the value, an optional memory address for stores, and a misprediction flag and an exception flag. Results may arrive in any order.

Retirement takes place only at the oldest slot. A finished normal entry is offered on a valid/ready commit stream to the register file or the store path. A finished branch that was mispredicted, or an entry that carries an exception, does not commit. It raises a one-cycle flush that empties the whole buffer. None of the younger speculative entries then reach machine state. A lookup port lets issue logic read the value and the ready bit of any tag before that entry commits.

Back-pressure rules: an allocation takes effect in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` depends only on buffer state and never on `alloc_valid`. A commit takes effect when `commit_valid` and `commit_ready` are both high. While `commit_ready` is low, the offered commit holds its contents. The result bus has no back-pressure.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `commit_valid`=0, `flush`=0, and every lookup returns `lk_ready`=0.
- R2: `alloc_tag` shows the slot that the next allocation takes. Each accepted allocation moves it forward by one, modulo DEPTH.
- R3: `alloc_ready` is 0 when all DEPTH slots are occupied, even in a cycle where a commit frees one. When the buffer is not full, an allocation and a commit in the same cycle both take effect.
- R4: A result-bus write whose tag names an occupied, unfinished slot stores the value, address and flags and marks the slot ready. A write to an unoccupied slot is ignored.
- R5: Only the oldest slot can commit, and only once its result is present. Entries therefore commit in allocation order even when results arrive out of order.
- R6: While `commit_valid`=1 and `commit_ready`=0, the offered commit stays valid with unchanged contents.
- R7: A commit presents the slot's kind, destination register, value and, for stores, the address. Kind encoding: 0 = register write, 1 = store, 2 = branch.
- R8: When the oldest slot is a finished, mispredicted entry, `flush`=1 with `flush_cause`=0 and `commit_valid`=0 for one cycle. In the next cycle the buffer is empty and tags restart at 0.
- R9: When the oldest slot is finished with its exception flag set, `flush`=1 with `flush_cause`=1 and no commit takes place. The buffer then empties as in R8.
- R10: `lk_value` and `lk_ready` return the stored value and the ready bit of slot `lk_tag`, reflecting result-bus writes up to the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_kind | input | 2 | Kind of the issuing instruction |
| alloc_dreg | input | RW | Destination register index |
| alloc_tag | output | log2(DEPTH) | Slot the next allocation takes |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | log2(DEPTH) | Slot the result belongs to |
| cdb_value | input | DW | Result value or store data |
| cdb_addr | input | DW | Store address |
| cdb_mispred | input | 1 | Branch was mispredicted |
| cdb_except | input | 1 | Instruction raised an exception |
| lk_tag | input | log2(DEPTH) | Slot to read |
| lk_value | output | DW | Stored value of that slot |
| lk_ready | output | 1 | That slot's result is present |
| commit_valid | output | 1 | Oldest slot offered for commit |
| commit_ready | input | 1 | Register file or store path accepts |
| commit_kind | output | 2 | Kind of the committing entry |
| commit_dreg | output | RW | Destination register |
| commit_value | output | DW | Value to write |
| commit_addr | output | DW | Store address |
| flush | output | 1 | Whole buffer is discarded this cycle |
| flush_cause | output | 1 | 0 misprediction, 1 exception |

## Verification
The bench builds the buffer with DEPTH=4, DW=16 and RW=5. With four slots, the full condition, the refused allocation while a commit frees a slot, and the wrap of both pointers all occur within a dozen cycles. The same short run also covers out-of-order result arrival, commit back-pressure, both flush causes, and lookups before and after a result lands.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;

  typedef enum logic {
    CAUSE_MISPRED = 1'b0,
    CAUSE_EXCEPT  = 1'b1
  } rob_cause_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          retire_fire,
  input  logic          flush,
  output logic [TW-1:0] head,
  output logic [TW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= tail + 1'b1;
      if (retire_fire) head <= head + 1'b1;
      count <= count + CW'(alloc_fire) - CW'(retire_fire);
    end
  end

  assign full = (count == CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_no_alloc_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire);
  assert_head_in_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire && !flush |=> head == TW'($past(head) + 1'b1));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0 && tail == '0 && head == '0);
endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter int DEPTH = 8,
  parameter int DW = 32,
  parameter int RW = 5,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_fire,
  input  logic [TW-1:0] alloc_idx,
  input  logic [1:0]    alloc_kind,
  input  logic [RW-1:0] alloc_dreg,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_value,
  input  logic [DW-1:0] cdb_addr,
  input  logic          cdb_mispred,
  input  logic          cdb_except,
  input  logic          retire_fire,
  input  logic [TW-1:0] head_idx,
  input  logic [TW-1:0] lk_tag,
  output logic          hd_valid,
  output logic          hd_rdy,
  output logic [1:0]    hd_kind,
  output logic [RW-1:0] hd_dreg,
  output logic [DW-1:0] hd_value,
  output logic [DW-1:0] hd_addr,
  output logic          hd_mispred,
  output logic          hd_except,
  output logic [DW-1:0] lk_value,
  output logic          lk_ready
);
  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] done;
  logic [DEPTH-1:0] misp;
  logic [DEPTH-1:0] exc;
  logic [1:0]       kind [DEPTH];
  logic [RW-1:0]    dreg [DEPTH];
  logic [DW-1:0]    val  [DEPTH];
  logic [DW-1:0]    adr  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          occ_q, done_q, misp_q, exc_q;
    logic [1:0]    kind_q;
    logic [RW-1:0] dreg_q;
    logic [DW-1:0] val_q, adr_q;
    logic          take, drop, fill;

    assign take = alloc_fire && (alloc_idx == TW'(i));
    assign drop = retire_fire && (head_idx == TW'(i));
    assign fill = cdb_valid && (cdb_tag == TW'(i)) && occ_q && !done_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
        misp_q <= 1'b0;
        exc_q  <= 1'b0;
        kind_q <= '0;
        dreg_q <= '0;
        val_q  <= '0;
        adr_q  <= '0;
      end else if (flush) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (take) begin
        occ_q  <= 1'b1;
        done_q <= 1'b0;
        misp_q <= 1'b0;
        exc_q  <= 1'b0;
        kind_q <= alloc_kind;
        dreg_q <= alloc_dreg;
      end else if (drop) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (fill) begin
        done_q <= 1'b1;
        val_q  <= cdb_value;
        adr_q  <= cdb_addr;
        misp_q <= cdb_mispred;
        exc_q  <= cdb_except;
      end
    end

    assign occ[i]  = occ_q;
    assign done[i] = done_q;
    assign misp[i] = misp_q;
    assign exc[i]  = exc_q;
    assign kind[i] = kind_q;
    assign dreg[i] = dreg_q;
    assign val[i]  = val_q;
    assign adr[i]  = adr_q;
  end

  assign hd_valid   = occ[head_idx];
  assign hd_rdy     = done[head_idx];
  assign hd_kind    = kind[head_idx];
  assign hd_dreg    = dreg[head_idx];
  assign hd_value   = val[head_idx];
  assign hd_addr    = adr[head_idx];
  assign hd_mispred = misp[head_idx];
  assign hd_except  = exc[head_idx];

  assign lk_value = val[lk_tag];
  assign lk_ready = done[lk_tag];

  assert_retire_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |-> occ[head_idx] && done[head_idx] && !misp[head_idx] && !exc[head_idx]);
  assert_cdb_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid && occ[cdb_tag] && !done[cdb_tag] && !flush
    |=> done[$past(cdb_tag)] && val[$past(cdb_tag)] == $past(cdb_value));
  assert_cdb_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid && !occ[cdb_tag] |=> !done[$past(cdb_tag)]);
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
(
  input  logic hd_valid,
  input  logic hd_rdy,
  input  logic hd_mispred,
  input  logic hd_except,
  input  logic commit_ready,
  output logic commit_valid,
  output logic retire_fire,
  output logic flush,
  output logic flush_cause
);
  logic finished;

  always_comb begin
    finished     = hd_valid && hd_rdy;
    flush        = finished && (hd_mispred || hd_except);
    commit_valid = finished && !hd_mispred && !hd_except;
    retire_fire  = commit_valid && commit_ready;
    flush_cause  = hd_except ? CAUSE_EXCEPT : CAUSE_MISPRED;
  end
endmodule

// File: rtl/rob_top.sv
module rob_top #(
  parameter int DEPTH = 8,
  parameter int DW = 32,
  parameter int RW = 5,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [1:0]    alloc_kind,
  input  logic [RW-1:0] alloc_dreg,
  output logic [TW-1:0] alloc_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_value,
  input  logic [DW-1:0] cdb_addr,
  input  logic          cdb_mispred,
  input  logic          cdb_except,
  input  logic [TW-1:0] lk_tag,
  output logic [DW-1:0] lk_value,
  output logic          lk_ready,
  output logic          commit_valid,
  input  logic          commit_ready,
  output logic [1:0]    commit_kind,
  output logic [RW-1:0] commit_dreg,
  output logic [DW-1:0] commit_value,
  output logic [DW-1:0] commit_addr,
  output logic          flush,
  output logic          flush_cause
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          alloc_fire, retire_fire, full;
  logic [TW-1:0] head, tail;
  logic [CW-1:0] count;
  logic          hd_valid, hd_rdy, hd_mispred, hd_except;

  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .retire_fire(retire_fire), .flush(flush),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  rob_slots #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) u_slots (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_fire(alloc_fire), .alloc_idx(tail),
    .alloc_kind(alloc_kind), .alloc_dreg(alloc_dreg),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_addr(cdb_addr), .cdb_mispred(cdb_mispred), .cdb_except(cdb_except),
    .retire_fire(retire_fire), .head_idx(head), .lk_tag(lk_tag),
    .hd_valid(hd_valid), .hd_rdy(hd_rdy), .hd_kind(commit_kind),
    .hd_dreg(commit_dreg), .hd_value(commit_value), .hd_addr(commit_addr),
    .hd_mispred(hd_mispred), .hd_except(hd_except),
    .lk_value(lk_value), .lk_ready(lk_ready)
  );

  rob_retire u_retire (
    .hd_valid(hd_valid), .hd_rdy(hd_rdy),
    .hd_mispred(hd_mispred), .hd_except(hd_except),
    .commit_ready(commit_ready), .commit_valid(commit_valid),
    .retire_fire(retire_fire), .flush(flush), .flush_cause(flush_cause)
  );

  assert_tag_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> alloc_tag == TW'($past(alloc_tag) + 1'b1));
  assert_commit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !commit_ready |=> commit_valid && $stable(commit_value) && $stable(commit_dreg));
  assert_flush_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !commit_valid && !alloc_ready);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: tb/tb_rob_top.sv
`timescale 1ns/1ps
module tb_rob_top;
  localparam int DEPTH = 4;
  localparam int DW = 16;
  localparam int RW = 5;
  localparam int TW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [1:0] alloc_kind = 0;
  logic [RW-1:0] alloc_dreg = 0;
  logic [TW-1:0] alloc_tag;
  logic cdb_valid = 0;
  logic [TW-1:0] cdb_tag = 0;
  logic [DW-1:0] cdb_value = 0, cdb_addr = 0;
  logic cdb_mispred = 0, cdb_except = 0;
  logic [TW-1:0] lk_tag = 0;
  logic [DW-1:0] lk_value;
  logic lk_ready;
  logic commit_valid, commit_ready = 0;
  logic [1:0] commit_kind;
  logic [RW-1:0] commit_dreg;
  logic [DW-1:0] commit_value, commit_addr;
  logic flush, flush_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_kind(alloc_kind), .alloc_dreg(alloc_dreg), .alloc_tag(alloc_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_addr(cdb_addr), .cdb_mispred(cdb_mispred), .cdb_except(cdb_except),
    .lk_tag(lk_tag), .lk_value(lk_value), .lk_ready(lk_ready),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_kind(commit_kind), .commit_dreg(commit_dreg),
    .commit_value(commit_value), .commit_addr(commit_addr),
    .flush(flush), .flush_cause(flush_cause)
  );

  typedef struct packed {
    logic av; logic [1:0] ak; logic [4:0] ar;
    logic cv; logic [1:0] ct; logic [15:0] cval; logic [15:0] cadr;
    logic cm; logic ce; logic crdy;
    logic x_ar; logic [1:0] x_tag; logic x_cv; logic [1:0] x_kind;
    logic [4:0] x_reg; logic [15:0] x_val; logic [15:0] x_adr;
    logic x_fl; logic x_cause;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1,0,1, 0,0,0,0,0,0,0, 1,0,0,0,0,0,0,0,0},
    '{1,0,2, 0,0,0,0,0,0,0, 1,1,0,0,0,0,0,0,0},
    '{1,1,0, 1,1,'h22,0,0,0,0, 1,2,0,0,0,0,0,0,0},
    '{1,0,4, 1,0,'h11,0,0,0,0, 1,3,0,0,0,0,0,0,0},
    '{1,0,9, 0,0,0,0,0,0,1, 0,0,1,0,1,'h11,0,0,0},
    '{1,0,5, 0,0,0,0,0,0,0, 1,0,1,0,2,'h22,0,0,0},
    '{0,0,0, 1,2,'h33,'h40,0,0,1, 0,1,1,0,2,'h22,0,0,0},
    '{0,0,0, 0,0,0,0,0,0,1, 1,1,1,1,0,'h33,'h40,0,0},
    '{0,0,0, 1,3,'h44,0,0,0,1, 1,1,0,0,0,0,0,0,0},
    '{0,0,0, 0,0,0,0,0,0,1, 1,1,1,0,4,'h44,0,0,0},
    '{1,2,0, 1,0,'h55,0,0,0,1, 1,1,0,0,0,0,0,0,0},
    '{1,0,6, 1,1,0,0,1,0,1, 1,2,1,0,5,'h55,0,0,0},
    '{1,0,8, 0,0,0,0,0,0,1, 0,3,0,0,0,0,0,1,0},
    '{1,0,7, 0,0,0,0,0,0,0, 1,0,0,0,0,0,0,0,0},
    '{0,0,0, 1,0,'h77,0,0,1,0, 1,1,0,0,0,0,0,0,0},
    '{0,0,0, 0,0,0,0,0,0,0, 0,1,0,0,0,0,0,1,1},
    '{0,0,0, 0,0,0,0,0,0,0, 1,0,0,0,0,0,0,0,0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; alloc_kind = 0; alloc_dreg = 0;
    cdb_valid = 0; cdb_tag = 0; cdb_value = 0; cdb_addr = 0;
    cdb_mispred = 0; cdb_except = 0; commit_ready = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1 reset state
    check("R1", "alloc_ready", 32'(alloc_ready), 1);
    check("R1", "alloc_tag", 32'(alloc_tag), 0);
    check("R1", "commit_valid", 32'(commit_valid), 0);
    check("R1", "flush", 32'(flush), 0);
    lk_tag = 1; #1;
    check("R1", "lk_ready", 32'(lk_ready), 0);

    // Table: R2 R3 R5 R6 R7 R8 R9 and R4 capture out of order
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      alloc_valid = VECS[i].av; alloc_kind = VECS[i].ak; alloc_dreg = VECS[i].ar;
      cdb_valid = VECS[i].cv; cdb_tag = VECS[i].ct; cdb_value = VECS[i].cval;
      cdb_addr = VECS[i].cadr; cdb_mispred = VECS[i].cm; cdb_except = VECS[i].ce;
      commit_ready = VECS[i].crdy;
      #1;
      check("R3", $sformatf("row %0d alloc_ready", i), 32'(alloc_ready), 32'(VECS[i].x_ar));
      check("R2", $sformatf("row %0d alloc_tag", i), 32'(alloc_tag), 32'(VECS[i].x_tag));
      check("R5", $sformatf("row %0d commit_valid", i), 32'(commit_valid), 32'(VECS[i].x_cv));
      check("R8", $sformatf("row %0d flush", i), 32'(flush), 32'(VECS[i].x_fl));
      if (VECS[i].x_fl)
        check("R9", $sformatf("row %0d flush_cause", i), 32'(flush_cause), 32'(VECS[i].x_cause));
      if (VECS[i].x_cv) begin
        check("R7", $sformatf("row %0d commit_kind", i), 32'(commit_kind), 32'(VECS[i].x_kind));
        check("R7", $sformatf("row %0d commit_dreg", i), 32'(commit_dreg), 32'(VECS[i].x_reg));
        check("R6", $sformatf("row %0d commit_value", i), 32'(commit_value), 32'(VECS[i].x_val));
        if (VECS[i].x_kind == 2'd1)
          check("R7", $sformatf("row %0d commit_addr", i), 32'(commit_addr), 32'(VECS[i].x_adr));
      end
    end

    // R4: result to an unoccupied slot is ignored
    @(negedge clk);
    idle_inputs();
    cdb_valid = 1; cdb_tag = 2; cdb_value = 16'h99;
    @(negedge clk);
    idle_inputs();
    lk_tag = 2; #1;
    check("R4", "ignored write lk_ready", 32'(lk_ready), 0);
    check("R4", "ignored write commit_valid", 32'(commit_valid), 0);

    // R10: lookup before and after the result lands
    alloc_valid = 1; alloc_kind = 0; alloc_dreg = 3;
    #1;
    check("R2", "directed alloc_tag", 32'(alloc_tag), 0);
    @(negedge clk);
    idle_inputs();
    lk_tag = 0; #1;
    check("R10", "lk_ready before result", 32'(lk_ready), 0);
    cdb_valid = 1; cdb_tag = 0; cdb_value = 16'habc;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R10", "lk_ready after result", 32'(lk_ready), 1);
    check("R10", "lk_value", 32'(lk_value), 32'h0abc);
    check("R5", "directed commit_valid", 32'(commit_valid), 1);
    commit_ready = 1;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R5", "after commit commit_valid", 32'(commit_valid), 0);
    check("R2", "after commit alloc_tag", 32'(alloc_tag), 1);

    // R1: reset while occupied
    alloc_valid = 1; alloc_dreg = 6;
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; lk_tag = 1; #1;
    check("R1", "re-reset alloc_tag", 32'(alloc_tag), 0);
    check("R1", "re-reset alloc_ready", 32'(alloc_ready), 1);
    check("R1", "re-reset commit_valid", 32'(commit_valid), 0);
    check("R1", "re-reset lk_ready", 32'(lk_ready), 0);

    done = 1;
    finish_run();
  end
endmodule